// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order 32-bit processor core. It splits each instruction across five stages: fetch, decode, execute, memory access and writeback. Registers between neighbouring stages hold the values a later stage will need. The core executes register-register add, subtract, AND and OR. It also executes word loads and word stores that form their address from a base register plus a signed 16-bit offset.

Control is decoded once, in the decode stage. It is split into three bundles, one for execute, one for memory and one for writeback. Each bundle rides with its instruction and is used up in the stage it belongs to. The instruction memory and data memory are small internal word arrays. They are filled through a load port while the core is held in reset. Every effective register-file write is mirrored on a debug port.

The instruction stream must not hold a dependency that needs result forwarding. A consumer may read a produced register no earlier than three instructions after its producer. Operand bypass between stages is left to a separate block.

Top module: `pipe5_core`

## Requirements
- R1: While reset is low, and until the first instruction reaches writeback, no register write and no memory store takes place. After reset is released, the first possible debug write appears after the fourth rising clock edge.
- R2: The program counter starts at zero and advances by 4 on every cycle. The instruction at word k writes back after rising edge k+4, so back-to-back instructions write back in consecutive cycles.
- R3: Instruction fields sit at fixed positions in every format: opcode [31:26], first source [25:21], second source [20:16], R-type destination [15:11], function [5:0], immediate [15:0]. Opcode 0x00 is R-type, with function 0x20 add, 0x22 subtract, 0x24 AND and 0x25 OR. Opcode 0x23 is load word and 0x2B is store word. Any other opcode or R-type function has no architectural effect.
- R4: An R-type result is written to the register in bits [15:11]. A load result is written to the register in bits [20:16].
- R5: A load reads the data word at byte address (first source + sign-extended immediate). The word index is that address divided by 4.
- R6: A store writes the second-source register value to the data word at (first source + sign-extended immediate) and writes no register.
- R7: Add and subtract wrap modulo 2^32. AND and OR are bitwise.
- R8: Register 0 always reads as zero, and writes aimed at it are discarded and not shown on the debug port.
- R9: A register written in writeback is read with its new value by an instruction in decode in the same cycle, so a consumer three instructions after its producer sees the result.
- R10: The debug port pulses for exactly one cycle per effective register write, with the register index and written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_imem_we | input | 1 | Preload write into instruction memory (only while reset is low) |
| ld_dmem_we | input | 1 | Preload write into data memory (only while reset is low) |
| ld_addr | input | 6 | Preload word index |
| ld_data | input | 32 | Preload word value |
| dbg_we | output | 1 | A register-file write takes effect this cycle |
| dbg_waddr | output | 5 | Index of the register being written |
| dbg_wdata | output | 32 | Value being written |

## Verification
Some rules are checked on every cycle by the embedded assertions. These are the +4 stride of the program counter, the absence of write enables in the first cycles after reset, and writeback control equalling the bundle that left the memory stage one cycle earlier. They also cover the mutual exclusion of load and store, address arithmetic always using addition, the zero register reading zero, and the same-cycle write-through.

The other behaviours are observed on the debug port by the directed scenarios. These are the ALU results, destination choice, offset sign handling, store-then-load round trips, ignored opcodes and the exact writeback cycle of each instruction.

// File: rtl/pipe5_pkg.sv
// Shared encodings and stage control bundles for the five-stage core.
// Assumes 32-bit instructions with fixed field positions.
package pipe5_pkg;

    localparam int INSTR_W = 32;
    localparam int RIDX_W  = 5;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;

    // Execute-stage bundle
    typedef struct packed {
        logic dst_is_rd;   // destination from [15:11] instead of [20:16]
        logic use_funct;   // ALU op from function field; else plain add
        logic b_is_imm;    // B operand is the extended immediate
    } ex_ctrl_t;

    // Memory-stage bundle
    typedef struct packed {
        logic rd;
        logic wr;
    } mem_ctrl_t;

    // Writeback-stage bundle
    typedef struct packed {
        logic we;
        logic from_mem;
    } wb_ctrl_t;

endpackage

// File: rtl/pipe5_decode.sv
// Decoder: turns opcode and function into the three stage bundles.
// Assumes: unsupported encodings must yield all-zero control (a bubble).
module pipe5_decode
    import pipe5_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ex_ctrl_t   ex_c,
    output mem_ctrl_t  mem_c,
    output wb_ctrl_t   wb_c
);

    logic funct_ok;

    // Recognise the supported R-type functions
    always_comb begin
        funct_ok = (funct == FN_ADD) || (funct == FN_SUB) ||
                   (funct == FN_AND) || (funct == FN_OR);
    end

    // Produce control bundles per opcode
    always_comb begin
        ex_c  = '0;
        mem_c = '0;
        wb_c  = '0;
        case (opcode)
            OP_RTYPE: begin
                if (funct_ok) begin
                    ex_c.dst_is_rd = 1'b1;
                    ex_c.use_funct = 1'b1;
                    wb_c.we        = 1'b1;
                end
            end
            OP_LOAD: begin
                ex_c.b_is_imm = 1'b1;
                mem_c.rd      = 1'b1;
                wb_c.we       = 1'b1;
                wb_c.from_mem = 1'b1;
            end
            OP_STORE: begin
                ex_c.b_is_imm = 1'b1;
                mem_c.wr      = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pipe5_alu.sv
// ALU: add for address formation, or the function-selected R-type op.
// Assumes the decoder has already filtered unsupported functions.
module pipe5_alu
    import pipe5_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            use_funct,
    input  logic [5:0]      funct,
    output logic [XLEN-1:0] y
);

    // Select the operation
    always_comb begin
        y = a + b;
        if (use_funct) begin
            case (funct)
                FN_SUB:  y = a - b;
                FN_AND:  y = a & b;
                FN_OR:   y = a | b;
                default: y = a + b;
            endcase
        end
    end

endmodule

// File: rtl/pipe5_regfile.sv
// Register file: two combinational reads, one write, entry 0 fixed at zero.
// A write in a cycle is visible to reads in that same cycle.
module pipe5_regfile #(
    parameter int XLEN  = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [XLEN-1:0]  wdata,
    input  logic [IDX_W-1:0] raddr_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [XLEN-1:0]  rdata_a,
    output logic [XLEN-1:0]  rdata_b
);

    localparam int NREG = 1 << IDX_W;

    logic [XLEN-1:0] regs [NREG];
    logic            wr_live;

    // Qualify writes: entry 0 is never written
    always_comb wr_live = we && (waddr != '0);

    // Clear on reset, then store qualified writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_live) begin
            regs[waddr] <= wdata;
        end
    end

    // Read with write-through of the value being written
    always_comb begin
        rdata_a = (raddr_a == '0) ? '0 :
                  (wr_live && raddr_a == waddr) ? wdata : regs[raddr_a];
        rdata_b = (raddr_b == '0) ? '0 :
                  (wr_live && raddr_b == waddr) ? wdata : regs[raddr_b];
    end

    a_r8_zero_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_a == '0) |-> (rdata_a == '0));

    a_r9_write_through: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0 && raddr_b == waddr) |-> (rdata_b == wdata));

endmodule

// File: rtl/pipe5_core.sv
// Five-stage in-order core: fetch, decode, execute, memory, writeback.
// Assumes dependent instructions are spaced three or more slots apart,
// and that memories are preloaded only while reset is held low.
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int MEM_WORDS = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ld_imem_we,
    input  logic                         ld_dmem_we,
    input  logic [$clog2(MEM_WORDS)-1:0] ld_addr,
    input  logic [XLEN-1:0]              ld_data,
    output logic                         dbg_we,
    output logic [RIDX_W-1:0]            dbg_waddr,
    output logic [XLEN-1:0]              dbg_wdata
);

    localparam int AW = $clog2(MEM_WORDS);

    typedef struct packed {
        ex_ctrl_t          ex;
        mem_ctrl_t         mem;
        wb_ctrl_t          wb;
        logic [XLEN-1:0]   a;
        logic [XLEN-1:0]   b;
        logic [XLEN-1:0]   imm;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [5:0]        funct;
    } idex_t;

    typedef struct packed {
        mem_ctrl_t         mem;
        wb_ctrl_t          wb;
        logic [XLEN-1:0]   res;
        logic [XLEN-1:0]   sdata;
        logic [RIDX_W-1:0] dst;
    } exmem_t;

    typedef struct packed {
        wb_ctrl_t          wb;
        logic [XLEN-1:0]   ldata;
        logic [XLEN-1:0]   res;
        logic [RIDX_W-1:0] dst;
    } memwb_t;

    logic [INSTR_W-1:0] imem [MEM_WORDS];
    logic [XLEN-1:0]    dmem [MEM_WORDS];

    logic [XLEN-1:0]    pc_q;
    logic [INSTR_W-1:0] if_instr;
    logic [INSTR_W-1:0] ifid_q;
    idex_t              idex_q, idex_d;
    exmem_t             exmem_q, exmem_d;
    memwb_t             memwb_q, memwb_d;

    ex_ctrl_t           dec_ex;
    mem_ctrl_t          dec_mem;
    wb_ctrl_t           dec_wb;
    logic [XLEN-1:0]    rs_val, rt_val;
    logic [XLEN-1:0]    alu_b, alu_y;
    logic [XLEN-1:0]    mem_rdata;
    logic [XLEN-1:0]    wb_data;
    logic               wb_we;

    logic               unused_bits;
    assign unused_bits = ^{pc_q[XLEN-1:AW+2], pc_q[1:0], ifid_q[10:6],
                           exmem_q.res[XLEN-1:AW+2], exmem_q.res[1:0]};

    // ---------------- Fetch ----------------

    // Program counter: one word per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_q + XLEN'(4);
    end

    // Instruction memory: written only by the preload port during reset
    always_ff @(posedge clk) begin
        if (!rst_n && ld_imem_we) imem[ld_addr] <= ld_data[INSTR_W-1:0];
    end

    assign if_instr = imem[pc_q[AW+1:2]];

    // IF/ID register: reset loads an all-zero word, which decodes as a bubble
    always_ff @(posedge clk) begin
        if (!rst_n) ifid_q <= '0;
        else        ifid_q <= if_instr;
    end

    // ---------------- Decode ----------------

    pipe5_decode u_dec (
        .opcode (ifid_q[31:26]),
        .funct  (ifid_q[5:0]),
        .ex_c   (dec_ex),
        .mem_c  (dec_mem),
        .wb_c   (dec_wb)
    );

    pipe5_regfile #(.XLEN(XLEN), .IDX_W(RIDX_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wb_we),
        .waddr   (memwb_q.dst),
        .wdata   (wb_data),
        .raddr_a (ifid_q[25:21]),
        .raddr_b (ifid_q[20:16]),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    // Assemble the ID/EX payload
    always_comb begin
        idex_d.ex    = dec_ex;
        idex_d.mem   = dec_mem;
        idex_d.wb    = dec_wb;
        idex_d.a     = rs_val;
        idex_d.b     = rt_val;
        idex_d.imm   = {{(XLEN-16){ifid_q[15]}}, ifid_q[15:0]};
        idex_d.rt    = ifid_q[20:16];
        idex_d.rd    = ifid_q[15:11];
        idex_d.funct = ifid_q[5:0];
    end

    // ID/EX register
    always_ff @(posedge clk) begin
        if (!rst_n) idex_q <= '0;
        else        idex_q <= idex_d;
    end

    // ---------------- Execute ----------------

    // B operand select
    always_comb alu_b = idex_q.ex.b_is_imm ? idex_q.imm : idex_q.b;

    pipe5_alu #(.XLEN(XLEN)) u_alu (
        .a         (idex_q.a),
        .b         (alu_b),
        .use_funct (idex_q.ex.use_funct),
        .funct     (idex_q.funct),
        .y         (alu_y)
    );

    // Assemble the EX/MEM payload, resolving the destination index
    always_comb begin
        exmem_d.mem   = idex_q.mem;
        exmem_d.wb    = idex_q.wb;
        exmem_d.res   = alu_y;
        exmem_d.sdata = idex_q.b;
        exmem_d.dst   = idex_q.ex.dst_is_rd ? idex_q.rd : idex_q.rt;
    end

    // EX/MEM register
    always_ff @(posedge clk) begin
        if (!rst_n) exmem_q <= '0;
        else        exmem_q <= exmem_d;
    end

    // ---------------- Memory ----------------

    // Data memory: preload during reset, stores afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (ld_dmem_we) dmem[ld_addr] <= ld_data;
        end else if (exmem_q.mem.wr) begin
            dmem[exmem_q.res[AW+1:2]] <= exmem_q.sdata;
        end
    end

    assign mem_rdata = dmem[exmem_q.res[AW+1:2]];

    // Assemble the MEM/WB payload
    always_comb begin
        memwb_d.wb    = exmem_q.wb;
        memwb_d.ldata = exmem_q.mem.rd ? mem_rdata : '0;
        memwb_d.res   = exmem_q.res;
        memwb_d.dst   = exmem_q.dst;
    end

    // MEM/WB register
    always_ff @(posedge clk) begin
        if (!rst_n) memwb_q <= '0;
        else        memwb_q <= memwb_d;
    end

    // ---------------- Writeback ----------------

    // Result select and effective write enable
    always_comb begin
        wb_data = memwb_q.wb.from_mem ? memwb_q.ldata : memwb_q.res;
        wb_we   = memwb_q.wb.we && (memwb_q.dst != '0);
    end

    assign dbg_we    = wb_we;
    assign dbg_waddr = memwb_q.dst;
    assign dbg_wdata = wb_data;

    // ---------------- Assertions ----------------

    a_r2_pc_stride: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pc_q == $past(pc_q) + XLEN'(4)));

    a_r1_no_enable_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!idex_q.mem.wr && !exmem_q.mem.wr && !memwb_q.wb.we));

    a_r10_wb_bundle_travels: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (memwb_q.wb == $past(exmem_q.wb)));

    a_r6_load_store_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(exmem_q.mem.rd && exmem_q.mem.wr));

    a_r5_addr_uses_add: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_q.mem.rd || idex_q.mem.wr) |-> (!idex_q.ex.use_funct && idex_q.ex.b_is_imm));

endmodule

// File: tb/pipe5_core_test.sv
module pipe5_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 64;
    localparam int MAXLOG     = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_imem_we = 1'b0;
    logic        ld_dmem_we = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic        dbg_we;
    logic [4:0]  dbg_waddr;
    logic [31:0] dbg_wdata;

    pipe5_core uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_imem_we (ld_imem_we),
        .ld_dmem_we (ld_dmem_we),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .dbg_we     (dbg_we),
        .dbg_waddr  (dbg_waddr),
        .dbg_wdata  (dbg_wdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int total_cycles = 0;

    logic [31:0] prog [WORDS];
    logic [31:0] data [WORDS];

    int          log_n = 0;
    int          log_cyc [MAXLOG];
    logic [4:0]  log_reg [MAXLOG];
    logic [31:0] log_dat [MAXLOG];

    // Edges since reset release
    always @(posedge clk) begin
        cyc <= rst_n ? cyc + 1 : 0;
        total_cycles <= total_cycles + 1;
    end

    // Record every debug write, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst_n) log_n = 0;
        else if (dbg_we && log_n < MAXLOG) begin
            log_cyc[log_n] = cyc;
            log_reg[log_n] = dbg_waddr;
            log_dat[log_n] = dbg_wdata;
            log_n = log_n + 1;
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        errors = errors + 1;
        $display("FAIL watchdog: act=timeout exp=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One logged write: index, value and cycle together
    task automatic expect_write(string tag, int idx, int rn, logic [31:0] d, int c);
        checks = checks + 1;
        if (idx >= log_n) begin
            errors = errors + 1;
            $display("FAIL %s: act=missing write #%0d exp=r%0d=%h @%0d", tag, idx, rn, d, c);
        end else if (log_reg[idx] != 5'(rn) || log_dat[idx] !== d || log_cyc[idx] != c) begin
            errors = errors + 1;
            $display("FAIL %s: act=r%0d=%h @%0d exp=r%0d=%h @%0d", tag,
                     log_reg[idx], log_dat[idx], log_cyc[idx], rn, d, c);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < WORDS; i++) begin
            prog[i] = 32'h0;
            data[i] = 32'h0;
        end
    endtask

    // Reset, preload both memories, release and run
    task automatic run_prog(int ncyc);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < WORDS; i++) begin
            @(negedge clk);
            ld_imem_we = 1'b1; ld_addr = 6'(i); ld_data = prog[i];
        end
        @(negedge clk);
        ld_imem_we = 1'b0;
        for (int i = 0; i < WORDS; i++) begin
            @(negedge clk);
            ld_dmem_we = 1'b1; ld_addr = 6'(i); ld_data = data[i];
        end
        @(negedge clk);
        ld_dmem_we = 1'b0;
        check("R1 debug idle in reset", {31'd0, dbg_we}, 32'd0);
        rst_n = 1'b1;
        repeat (ncyc) @(negedge clk);
    endtask

    // Loads back to back: reset latency and throughput
    task automatic t_loads();
        clear_mem();
        data[0] = 32'h0000_0011; data[1] = 32'h0000_0022;
        data[2] = 32'hFFFF_FFF0; data[3] = 32'h0000_0007;
        prog[0] = enc_i(6'h23, 0, 1, 0);
        prog[1] = enc_i(6'h23, 0, 2, 4);
        prog[2] = enc_i(6'h23, 0, 3, 8);
        prog[3] = enc_i(6'h23, 0, 4, 12);
        run_prog(12);
        check("R1 first write not before cycle 4", (log_n > 0 && log_cyc[0] < 4) ? 1 : 0, 0);
        expect_write("R5 R4 load to rt", 0, 1, 32'h11, 4);
        expect_write("R2 next cycle", 1, 2, 32'h22, 5);
        expect_write("R2 next cycle", 2, 3, 32'hFFFF_FFF0, 6);
        expect_write("R2 next cycle", 3, 4, 32'h7, 7);
        check("R10 write count", log_n, 4);
    endtask

    // R-type operations, including same-cycle write-through
    task automatic t_alu();
        logic [31:0] x, y, p, q;
        x = 32'h0000_F0F0; y = 32'h0000_0FF5; p = 32'h7FFF_FFFF; q = 32'h1;
        clear_mem();
        data[0] = x; data[1] = y; data[2] = p; data[3] = q;
        prog[0] = enc_i(6'h23, 0, 1, 0);
        prog[1] = enc_i(6'h23, 0, 2, 4);
        prog[2] = enc_i(6'h23, 0, 3, 8);
        prog[3] = enc_i(6'h23, 0, 4, 12);
        prog[4] = enc_r(1, 2, 5, 6'h20);   // reads r2 in its writeback cycle
        prog[5] = enc_r(2, 1, 6, 6'h22);
        prog[6] = enc_r(1, 2, 7, 6'h24);
        prog[7] = enc_r(1, 2, 8, 6'h25);
        prog[8] = enc_r(3, 4, 9, 6'h20);
        prog[9] = enc_r(0, 4, 10, 6'h22);
        run_prog(18);
        expect_write("R9 R7 add with write-through", 4, 5, x + y, 8);
        expect_write("R7 sub negative", 5, 6, y - x, 9);
        expect_write("R7 and", 6, 7, x & y, 10);
        expect_write("R7 or", 7, 8, x | y, 11);
        expect_write("R7 add wraps", 8, 9, 32'h8000_0000, 12);
        expect_write("R7 R4 sub to rd", 9, 10, 32'hFFFF_FFFF, 13);
    endtask

    // Store then load, signed offsets
    task automatic t_store();
        clear_mem();
        data[0] = 32'd20; data[5] = 32'h1234_5678;
        data[3] = 32'h0000_DEAD; data[4] = 32'hCAFE_0004;
        prog[0] = enc_i(6'h23, 0, 1, 0);
        prog[1] = enc_i(6'h23, 0, 2, 20);
        prog[4] = enc_i(6'h2B, 1, 2, -8);   // word 3
        prog[5] = enc_i(6'h23, 0, 3, 12);
        prog[6] = enc_i(6'h23, 1, 4, -4);   // word 4
        run_prog(16);
        expect_write("R5 base load", 0, 1, 32'd20, 4);
        expect_write("R5 load", 1, 2, 32'h1234_5678, 5);
        expect_write("R6 store visible to load", 2, 3, 32'h1234_5678, 9);
        expect_write("R5 negative offset", 3, 4, 32'hCAFE_0004, 10);
        check("R6 store writes no register", log_n, 4);
    endtask

    // Register zero and unsupported encodings
    task automatic t_zero_and_illegal();
        clear_mem();
        data[0] = 32'h55; data[1] = 32'h66;
        prog[0] = enc_i(6'h23, 0, 0, 0);       // load into r0
        prog[1] = enc_i(6'h23, 0, 1, 4);
        prog[2] = enc_i(6'h3F, 1, 2, 4);       // unknown opcode
        prog[3] = enc_r(1, 1, 3, 6'h27);       // unknown function
        prog[4] = enc_r(0, 1, 5, 6'h25);       // r0 | r1
        run_prog(14);
        expect_write("R8 r0 write hidden, r1 loads", 0, 1, 32'h66, 5);
        expect_write("R8 r0 still reads zero", 1, 5, 32'h66, 8);
        check("R3 unknown encodings have no effect", log_n, 2);
    endtask

    initial begin
        t_loads();
        t_alu();
        t_store();
        t_zero_and_illegal();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule